// File: doc/BRIEF.md
# Multiplexed Bus Target with Configuration Header

This block is a single-function target on a 32-bit multiplexed address/data bus. On the clock where the master first pulls its cycle-active strobe low, the block captures the address from the shared lines and the command from the four lane-control lines. It then decides whether to claim the cycle. It accepts two kinds of cycle: memory reads and writes that fall inside one base address window, and configuration reads and writes that reach a small header of dword registers. Configuration cycles are claimed only while the per-slot select input is high.

Once it claims a cycle, the block runs a burst of data phases. A word moves only on a clock where the master-ready and target-ready strobes are both low. The master's cycle-active strobe going high marks the final phase. Memory words reach a simple local port, which has a word address, a write strobe, lane enables and combinational read data. Configuration words reach internal registers. While the block drives read data it also drives even parity, one clock behind the data. A cycle that nothing decodes is left unclaimed, so the master ends it with an abort.

Top module: `pbus_target`

## Requirements
- R1: While reset is held, and after it is released, `claimN` and `tgtRdyN` are high, and `busOutEn`, `parOutEn` and `memWe` are low.
- R2: On `laneCmdN` during the address phase, codes 0110, 1100 and 1110 are memory reads, 0111 and 1111 are memory writes, 1010 is a configuration read and 1011 is a configuration write. Every other code, for example 0010, is never claimed.
- R3: Let the address phase be sampled at edge E0. A claimed cycle pulls `claimN` low after edge E1. A write pulls `tgtRdyN` low after E1 as well. A read pulls `tgtRdyN` low and raises `busOutEn` one clock later, after E2.
- R4: A word transfers only at an edge where both `mstRdyN` and `tgtRdyN` are low. A clock with `mstRdyN` high moves nothing and the target keeps `tgtRdyN` low. Each transfer advances the dword address by one.
- R5: A transfer with `xferActN` high is the last one. After that edge, `claimN` and `tgtRdyN` are high and `busOutEn` is low.
- R6: During data phases, `laneCmdN[i]` low enables byte i (bits 8i+7:8i). On memory writes `memBe` = ~`laneCmdN`. Configuration writes change only the enabled bytes.
- R7: A configuration cycle is claimed only when `cfgSelect` is high and `busIn[1:0]` is 00 in the address phase. `busIn[7:2]` selects the header dword.
- R8: The header holds these dwords. Byte offset 0x00 is {DEVICE_ID, VENDOR_ID}. 0x04 has bits 31:2 reading zero and a writable bit 1 (memory enable). 0x08 is {CLASS_CODE, REVISION}. 0x0C has a writable byte 0 (line size) and a writable byte 1 (latency), with bytes 3:2 reading zero. 0x10 is the base address. 0x3C has a writable byte 0 and bits 31:8 reading zero. Every other offset reads zero.
- R9: Base-address bits below BAR_BITS always read zero, whatever is written to them.
- R10: A memory cycle is claimed only if the memory-enable bit is set and `busIn[31:BAR_BITS]` equals the base address bits above BAR_BITS.
- R11: `parOutEn` is high exactly in the clock after each clock in which `busOutEn` is high. At that time `parOut` makes the XOR of the previous clock's `busOut` and `laneCmdN` (36 bits) even, so it equals the XOR of those bits.
- R12: An unclaimed cycle keeps `claimN` and `tgtRdyN` high, `busOutEn` low and `memWe` low until the bus is idle, that is, until `xferActN` and `mstRdyN` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xferActN | input | 1 | Master cycle-active strobe, active low |
| mstRdyN | input | 1 | Master ready, active low |
| cfgSelect | input | 1 | Per-slot configuration select |
| laneCmdN | input | 4 | Command in address phase, byte enables (active low) in data phases |
| busIn | input | 32 | Address/data lines as seen by the target |
| busOut | output | 32 | Read data driven by the target |
| busOutEn | output | 1 | Target drives the address/data lines |
| claimN | output | 1 | Target claims the cycle, active low |
| tgtRdyN | output | 1 | Target ready, active low |
| parOut | output | 1 | Even parity over the previous clock's data and lane lines |
| parOutEn | output | 1 | Target drives parity |
| memAddr | output | BAR_BITS-2 | Local dword address |
| memWe | output | 1 | Local write strobe |
| memBe | output | 4 | Local byte enables, active high |
| memWdata | output | 32 | Local write data |
| memRdata | input | 32 | Local read data, combinational from memAddr |

## Verification
The hardest behaviour to reach from the ports is a read burst in which the master inserts a wait clock after the first transfer. In that case the target must hold its prefetched word and its ready strobe, and load the next dword only on the following real transfer. The bench drives bursts with a wait placed on a chosen clock, and compares every transferred word against its own store and every clock's parity against its own sampled XOR. Abort paths come from three sources: an unused command code, a configuration cycle without select or with nonzero low address bits, and a memory address outside the window or issued before the enable bit is set.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_TURN,
    ST_DATA,
    ST_ABORT
  } tgtStateT;

  typedef struct packed {
    logic capAddr;   // latch start address
    logic xfer;      // a word moves at this edge
    logic loadRead;  // refill the read output register
    logic cfgSpace;  // cycle targets the header
    logic writeDir;  // cycle is a write
  } dpCtlT;

  function automatic logic cmdMemRd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
  endfunction

  function automatic logic cmdMemWr(input logic [3:0] c);
    return (c == 4'b0111) || (c == 4'b1111);
  endfunction

  function automatic logic cmdCfgRd(input logic [3:0] c);
    return c == 4'b1010;
  endfunction

  function automatic logic cmdCfgWr(input logic [3:0] c);
    return c == 4'b1011;
  endfunction

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferActN,
  input  logic       mstRdyN,
  input  logic       cfgSelect,
  input  logic [3:0] laneCmdN,
  input  logic [1:0] adLow,
  input  logic       memEn,
  input  logic       addrMatch,
  output dpCtlT      ctl,
  output logic       claimN,
  output logic       tgtRdyN,
  output logic       busOutEn,
  output logic       memWe
);

  tgtStateT state;
  logic     isWr;
  logic     isCfg;
  logic     memHit;
  logic     cfgHit;
  logic     hit;
  logic     wrCmd;
  logic     cfgCmd;
  logic     xferNow;

  always_comb begin
    wrCmd  = cmdMemWr(laneCmdN) || cmdCfgWr(laneCmdN);
    cfgCmd = cmdCfgRd(laneCmdN) || cmdCfgWr(laneCmdN);
    memHit = (cmdMemRd(laneCmdN) || cmdMemWr(laneCmdN)) && memEn && addrMatch;
    cfgHit = cfgCmd && cfgSelect && (adLow == 2'b00);
    hit    = memHit || cfgHit;
  end

  assign xferNow = (state == ST_DATA) && !mstRdyN && !tgtRdyN;

  always_comb begin
    ctl.capAddr  = (state == ST_IDLE) && !xferActN;
    ctl.xfer     = xferNow;
    ctl.loadRead = (state == ST_TURN) || (xferNow && !isWr && !xferActN);
    ctl.cfgSpace = isCfg;
    ctl.writeDir = isWr;
  end

  assign memWe = xferNow && isWr && !isCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWr     <= 1'b0;
      isCfg    <= 1'b0;
      claimN   <= 1'b1;
      tgtRdyN  <= 1'b1;
      busOutEn <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!xferActN) begin
            isWr  <= wrCmd;
            isCfg <= cfgCmd;
            state <= hit ? ST_DECODE : ST_ABORT;
          end
        end
        ST_DECODE: begin
          claimN <= 1'b0;
          if (isWr) begin
            tgtRdyN <= 1'b0;
            state   <= ST_DATA;
          end else begin
            state <= ST_TURN;
          end
        end
        ST_TURN: begin
          tgtRdyN  <= 1'b0;
          busOutEn <= 1'b1;
          state    <= ST_DATA;
        end
        ST_DATA: begin
          if (xferNow && xferActN) begin
            claimN   <= 1'b1;
            tgtRdyN  <= 1'b1;
            busOutEn <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_ABORT: begin
          if (xferActN && mstRdyN) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the ready strobe is never given without a claim
  a_r3_ready_needs_claim: assert property (@(posedge clk) disable iff (!rstN)
    !tgtRdyN |-> !claimN);

  // R12: the data lines are only driven inside a claimed cycle
  a_r12_drive_needs_claim: assert property (@(posedge clk) disable iff (!rstN)
    busOutEn |-> !claimN);

  // R3: a read's first ready follows the claim by one turnaround clock
  a_r3_read_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tgtRdyN) && busOutEn) |-> (!$past(claimN) && !$past(busOutEn)));

  // R3: a write's ready appears together with the claim
  a_r3_write_claim_ready: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tgtRdyN) && !busOutEn) |-> $fell(claimN));

  // R4: a master wait clock does not withdraw target ready
  a_r4_ready_held_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    (!tgtRdyN && mstRdyN) |=> !tgtRdyN);

  // R12: an abort never claims or signals ready
  a_r12_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ABORT) |-> (claimN && tgtRdyN && !memWe));

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int          BAR_BITS   = 12,
  parameter logic [15:0] VENDOR_ID  = 16'h5A17,
  parameter logic [15:0] DEVICE_ID  = 16'h0C31,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  localparam int         WIDX       = BAR_BITS - 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtlT           ctl,
  input  logic [31:0]     busIn,
  input  logic [3:0]      laneCmdN,
  input  logic [31:0]     memRdata,
  input  logic            busOutEn,
  output logic [31:0]     busOut,
  output logic            parOut,
  output logic            parOutEn,
  output logic [WIDX-1:0] memAddr,
  output logic [3:0]      memBe,
  output logic [31:0]     memWdata,
  output logic            memEn,
  output logic            addrMatch
);

  localparam int HI_W = 32 - BAR_BITS;

  logic [WIDX-1:0] wordIdx;
  logic [WIDX-1:0] nextIdx;
  logic [HI_W-1:0] barHi;
  logic [7:0]      lineSize;
  logic [7:0]      latTimer;
  logic [7:0]      intLine;
  logic [31:0]     barFull;
  logic [31:0]     barMerged;
  logic [31:0]     cfgWord;
  logic [3:0]      laneEn;

  assign laneEn    = ~laneCmdN;
  assign memBe     = laneEn;
  assign memWdata  = busIn;
  assign barFull   = {barHi, {BAR_BITS{1'b0}}};
  assign addrMatch = (busIn[31:BAR_BITS] == barHi);
  assign nextIdx   = ctl.xfer ? wordIdx + 1'b1 : wordIdx;
  assign memAddr   = ctl.writeDir ? wordIdx : nextIdx;

  for (genvar b = 0; b < 4; b++) begin : g_barLane
    assign barMerged[b*8 +: 8] = laneEn[b] ? busIn[b*8 +: 8] : barFull[b*8 +: 8];
  end

  always_comb begin
    unique case (nextIdx[5:0])
      6'd0:    cfgWord = {DEVICE_ID, VENDOR_ID};
      6'd1:    cfgWord = {30'd0, memEn, 1'b0};
      6'd2:    cfgWord = {CLASS_CODE, REVISION};
      6'd3:    cfgWord = {16'd0, latTimer, lineSize};
      6'd4:    cfgWord = barFull;
      6'd15:   cfgWord = {24'd0, intLine};
      default: cfgWord = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      busOut  <= '0;
    end else begin
      if (ctl.capAddr) wordIdx <= busIn[BAR_BITS-1:2];
      else if (ctl.xfer) wordIdx <= wordIdx + 1'b1;
      if (ctl.loadRead) busOut <= ctl.cfgSpace ? cfgWord : memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memEn    <= 1'b0;
      lineSize <= '0;
      latTimer <= '0;
      intLine  <= '0;
      barHi    <= '0;
    end else if (ctl.xfer && ctl.writeDir && ctl.cfgSpace) begin
      unique case (wordIdx[5:0])
        6'd1: if (laneEn[0]) memEn <= busIn[1];
        6'd3: begin
          if (laneEn[0]) lineSize <= busIn[7:0];
          if (laneEn[1]) latTimer <= busIn[15:8];
        end
        6'd4:  barHi <= barMerged[31:BAR_BITS];
        6'd15: if (laneEn[0]) intLine <= busIn[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOut   <= 1'b0;
      parOutEn <= 1'b0;
    end else begin
      parOutEn <= busOutEn;
      parOut   <= ^{busOut, laneCmdN};
    end
  end

  // R4: the burst address only moves on a transfer or a new cycle
  a_r4_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.xfer && !ctl.capAddr) |=> $stable(wordIdx));

  // R11: parity is driven only behind a driven data clock
  a_r11_parity_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parOutEn) |-> $past(busOutEn));

endmodule

// File: rtl/pbus_target.sv
module pbus_target
  import pbus_pkg::*;
#(
  parameter int          BAR_BITS   = 12,
  parameter logic [15:0] VENDOR_ID  = 16'h5A17,
  parameter logic [15:0] DEVICE_ID  = 16'h0C31,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  localparam int         WIDX       = BAR_BITS - 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            xferActN,
  input  logic            mstRdyN,
  input  logic            cfgSelect,
  input  logic [3:0]      laneCmdN,
  input  logic [31:0]     busIn,
  output logic [31:0]     busOut,
  output logic            busOutEn,
  output logic            claimN,
  output logic            tgtRdyN,
  output logic            parOut,
  output logic            parOutEn,
  output logic [WIDX-1:0] memAddr,
  output logic            memWe,
  output logic [3:0]      memBe,
  output logic [31:0]     memWdata,
  input  logic [31:0]     memRdata
);

  dpCtlT ctl;
  logic  memEn;
  logic  addrMatch;

  pbus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xferActN  (xferActN),
    .mstRdyN   (mstRdyN),
    .cfgSelect (cfgSelect),
    .laneCmdN  (laneCmdN),
    .adLow     (busIn[1:0]),
    .memEn     (memEn),
    .addrMatch (addrMatch),
    .ctl       (ctl),
    .claimN    (claimN),
    .tgtRdyN   (tgtRdyN),
    .busOutEn  (busOutEn),
    .memWe     (memWe)
  );

  pbus_datapath #(
    .BAR_BITS   (BAR_BITS),
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .CLASS_CODE (CLASS_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busIn     (busIn),
    .laneCmdN  (laneCmdN),
    .memRdata  (memRdata),
    .busOutEn  (busOutEn),
    .busOut    (busOut),
    .parOut    (parOut),
    .parOutEn  (parOutEn),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .memEn     (memEn),
    .addrMatch (addrMatch)
  );

endmodule

// File: tb/sim_pbus_target.sv
module sim_pbus_target;

  localparam int BAR_BITS = 12;
  localparam int WIDX     = BAR_BITS - 2;
  localparam int DEPTH    = 1 << WIDX;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            xferActN = 1'b1;
  logic            mstRdyN = 1'b1;
  logic            cfgSelect = 1'b0;
  logic [3:0]      laneCmdN = 4'hF;
  logic [31:0]     busIn = '0;
  logic [31:0]     busOut;
  logic            busOutEn, claimN, tgtRdyN, parOut, parOutEn, memWe;
  logic [WIDX-1:0] memAddr;
  logic [3:0]      memBe;
  logic [31:0]     memWdata, memRdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0] store [DEPTH];
  logic [31:0] wrD  [8];
  logic [3:0]  beD  [8];
  logic [31:0] expD [8];

  always #5 clk = ~clk;

  pbus_target #(.BAR_BITS(BAR_BITS)) u0 (
    .clk(clk), .rstN(rstN), .xferActN(xferActN), .mstRdyN(mstRdyN),
    .cfgSelect(cfgSelect), .laneCmdN(laneCmdN), .busIn(busIn),
    .busOut(busOut), .busOutEn(busOutEn), .claimN(claimN), .tgtRdyN(tgtRdyN),
    .parOut(parOut), .parOutEn(parOutEn), .memAddr(memAddr), .memWe(memWe),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata)
  );

  // local store seen through the block's memory port
  assign memRdata = store[memAddr];
  always @(posedge clk) begin
    if (memWe) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) store[memAddr][b*8 +: 8] <= memWdata[b*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R11 parity reference: sample at the edge, compare one clock later
  logic sOe = 1'b0;
  logic sPar = 1'b0;
  always @(posedge clk) begin
    if (rstN) begin
      sOe  <= busOutEn;
      sPar <= ^{busOut, laneCmdN};
    end
  end
  always @(negedge clk) begin
    if (rstN) begin
      chk(parOutEn == sOe, "R11 parity enable", {31'd0, parOutEn}, {31'd0, sOe});
      if (sOe) chk(parOut == sPar, "R11 parity value", {31'd0, parOut}, {31'd0, sPar});
    end
  end

  function automatic logic [31:0] initWord(input int i);
    return 32'h9E3779B9 * i + 32'h0000_1234;
  endfunction

  // One bus cycle as master. waitJ: clock on which master withholds ready.
  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr,
                      input logic sel, input int n, input bit claim,
                      input int waitJ, input string req);
    bit isWr = cmd[0];
    int j = 1;
    int k = 0;
    bit done = 0;
    bit mRdy;
    @(negedge clk);
    xferActN  = 1'b0;
    mstRdyN   = 1'b1;
    busIn     = addr;
    laneCmdN  = cmd;
    cfgSelect = sel;
    @(negedge clk);
    while (!done) begin
      if (claim) begin
        chk(claimN == !(j >= 2), {req, " R3 claim timing"}, {31'd0, claimN}, {31'd0, !(j >= 2)});
        chk(tgtRdyN == !(j >= (isWr ? 2 : 3)), {req, " R3 ready timing"},
            {31'd0, tgtRdyN}, {31'd0, !(j >= (isWr ? 2 : 3))});
        chk(busOutEn == (!isWr && j >= 3), {req, " R3 drive timing"},
            {31'd0, busOutEn}, {31'd0, (!isWr && j >= 3)});
        mRdy     = (j != waitJ);
        mstRdyN  = !mRdy;
        xferActN = (k == n - 1) && mRdy;
        busIn    = isWr ? wrD[k] : 32'd0;
        laneCmdN = beD[k];
        if (mRdy && !tgtRdyN) begin
          if (!isWr)
            chk(busOut == expD[k], {req, " R4 read word"}, busOut, expD[k]);
          k++;
          if (k == n) done = 1;
        end
      end else begin
        chk(claimN && tgtRdyN && !busOutEn && !memWe, {req, " R12 abort silent"},
            {28'd0, claimN, tgtRdyN, busOutEn, memWe}, 32'hC);
        mstRdyN  = 1'b0;
        busIn    = 32'd0;
        laneCmdN = 4'h0;
        xferActN = (j == 4);
        if (j == 4) done = 1;
      end
      j++;
      if (j > 40) done = 1;
      @(negedge clk);
    end
    chk(claimN && tgtRdyN && !busOutEn, {req, " R5 end of cycle"},
        {29'd0, claimN, tgtRdyN, busOutEn}, 32'h6);
    xferActN  = 1'b1;
    mstRdyN   = 1'b1;
    laneCmdN  = 4'hF;
    busIn     = 32'd0;
    cfgSelect = 1'b0;
  endtask

  task automatic cfgWr1(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    wrD[0] = d; beD[0] = be;
    xact(4'b1011, {24'd0, off}, 1'b1, 1, 1, -1, "R8 cfg write");
  endtask

  task automatic cfgRd1(input logic [7:0] off, input logic [31:0] e, input string req);
    beD[0] = 4'h0; expD[0] = e;
    xact(4'b1010, {24'd0, off}, 1'b1, 1, 1, -1, req);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = initWord(i);
    for (int i = 0; i < 8; i++) begin wrD[i] = '0; beD[i] = '0; expD[i] = '0; end
    repeat (3) @(negedge clk);
    chk(claimN && tgtRdyN && !busOutEn && !parOutEn && !memWe, "R1 reset state",
        {27'd0, claimN, tgtRdyN, busOutEn, parOutEn, memWe}, 32'h18);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(claimN && tgtRdyN && !busOutEn && !parOutEn && !memWe, "R1 after reset",
        {27'd0, claimN, tgtRdyN, busOutEn, parOutEn, memWe}, 32'h18);

    cfgRd1(8'h00, 32'h0C31_5A17, "R8 R7 ids");
    cfgWr1(8'h10, 32'hFFFF_FFFF, 4'h0);
    cfgRd1(8'h10, 32'hFFFF_F000, "R9 base size");
    cfgWr1(8'h10, 32'h8000_0000, 4'h0);
    // R10: memory not enabled yet
    xact(4'b0110, 32'h8000_0000, 1'b0, 1, 0, -1, "R10 disabled");
    cfgWr1(8'h04, 32'h0000_FFFF, 4'h0);
    cfgRd1(8'h04, 32'h0000_0002, "R8 command");

    // R4 R6: write burst with a master wait
    for (int i = 0; i < 4; i++) begin wrD[i] = 32'hC0DE_0000 + i; beD[i] = 4'h0; end
    xact(4'b0111, 32'h8000_0010, 1'b0, 4, 1, 3, "R4 write burst");
    for (int i = 0; i < 4; i++)
      chk(store[4 + i] == 32'hC0DE_0000 + i, "R4 written word", store[4 + i], 32'hC0DE_0000 + i);

    // R6 R2: partial lanes via write-and-invalidate code
    wrD[0] = 32'h1122_3344; beD[0] = 4'b1010;
    xact(4'b1111, 32'h8000_0020, 1'b0, 1, 1, -1, "R2 R6 partial write");
    begin
      logic [31:0] e = initWord(8);
      e[23:16] = 8'h22; e[7:0] = 8'h44;
      chk(store[8] == e, "R6 byte lanes", store[8], e);
    end

    // R4 R11: read burst with a wait after the first transfer
    for (int i = 0; i < 3; i++) begin expD[i] = 32'hC0DE_0000 + i; beD[i] = 4'h0; end
    beD[1] = 4'b0110;
    xact(4'b0110, 32'h8000_0010, 1'b0, 3, 1, 4, "R4 read burst");
    expD[0] = initWord(16); beD[0] = 4'h0;
    xact(4'b1100, 32'h8000_0040, 1'b0, 1, 1, -1, "R2 read multiple");
    expD[0] = initWord(17);
    xact(4'b1110, 32'h8000_0044, 1'b0, 1, 1, -1, "R2 read line");

    xact(4'b0010, 32'h8000_0000, 1'b0, 1, 0, -1, "R2 unused code");
    xact(4'b1010, 32'h0000_0000, 1'b0, 1, 0, -1, "R7 no select");
    xact(4'b1010, 32'h0000_0001, 1'b1, 1, 0, -1, "R7 low bits");
    xact(4'b0110, 32'h9000_0000, 1'b0, 1, 0, -1, "R10 outside window");

    // R6 R8: lane-limited header write, then header burst read
    cfgWr1(8'h0C, 32'hAABB_CC10, 4'b1110);
    for (int i = 0; i < 3; i++) beD[i] = 4'h0;
    expD[0] = 32'h0580_0003; expD[1] = 32'h0000_0010; expD[2] = 32'h8000_0000;
    xact(4'b1010, 32'h0000_0008, 1'b1, 3, 1, -1, "R8 header burst");
    cfgRd1(8'h20, 32'h0000_0000, "R8 unused offset");
    cfgWr1(8'h3C, 32'hFFFF_FFFF, 4'h0);
    cfgRd1(8'h3C, 32'h0000_00FF, "R8 line register");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule